// File: doc/BRIEF.md
# Two-Port Mailbox with Masked Interrupts

This block gives two processors a small shared register space for passing short messages. Each side has its own port with a chip enable, a write strobe, an output enable, two byte enables, a six-bit address and 16-bit write and read data. When a port pulls its mailbox-select input low, its address selects the mailbox space. When the select is high, the address belongs to main memory, which lives outside this block, and the block ignores the access.

Each port owns four outgoing 16-bit mailboxes. A write into outgoing mailbox n raises flag n for the opposite port. That port reads the message through its incoming window, and the read clears the flag. Each port holds a 4-bit mask. The port's interrupt line is high while any flag bit is set whose mask bit is also set. All state changes on the rising clock edge. Read data is combinational from the current state and the port's control inputs.

Port A is named first in the port list and port B second. The two ports behave identically.

Top module: `xport_mailbox`

## Requirements
- R1: After reset, all mailboxes, flags and masks are zero and both interrupt outputs are low.
- R2: While a port's mailbox-select input `*_mbx_n` is high, that port's reads return zero and its writes change no mailbox, flag or mask.
- R3: Mailbox address map for each port:
  - Addresses 0 to 3 are the port's own outgoing mailboxes.
  - A write (`cs_n`=0, `mbx_n`=0, `we_n`=0) stores only the bytes whose active-low byte enable is 0. `be_n[0]` controls bits 7:0 and `be_n[1]` controls bits 15:8.
  - The stored value reads back at the same address.
- R4: A write to outgoing mailbox n (address n, 0 to 3) with at least one byte enabled sets bit n of the opposite port's flag register. The flag register reads at address 9 in bits 3:0.
- R5: A read (`cs_n`=0, `mbx_n`=0, `oe_n`=0, `we_n`=1) of address 4+n returns the opposite port's outgoing mailbox n and clears the reader's own flag n at that clock edge.
- R6: If a flag is set and cleared in the same cycle, it ends up set.
- R7: Interrupt masking:
  - Address 8 holds a port's 4-bit mask in bits 3:0. It is written when `be_n[0]` is 0 and reads back at address 8.
  - A port's interrupt output is high exactly while (flag AND mask) is nonzero.
  - A mask write changes the interrupt only from the next rising edge.
- R8: Addresses 10 to 63 read as zero. Writes to addresses 4 to 7, 9 and 10 to 63 change nothing.
- R9: Read data is zero unless `cs_n`=0, `mbx_n`=0, `oe_n`=0 and `we_n`=1. A byte whose `be_n` bit is 1 reads as zero.
- R10: While a port's chip enable `*_cs_n` is high, its writes and reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_cs_n | input | 1 | Port A chip enable, active low |
| a_mbx_n | input | 1 | Port A mailbox select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_be_n | input | 2 | Port A byte enables, active low, bit 0 controls the low byte |
| a_addr | input | 6 | Port A mailbox address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data |
| a_irq | output | 1 | Port A interrupt, active high |
| b_cs_n | input | 1 | Port B chip enable, active low |
| b_mbx_n | input | 1 | Port B mailbox select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_be_n | input | 2 | Port B byte enables, active low, bit 0 controls the low byte |
| b_addr | input | 6 | Port B mailbox address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data |
| b_irq | output | 1 | Port B interrupt, active high |

## Verification
Messages are sent in both directions on different mailbox indices. This separates which port's flag a write raises and which bit it raises. Partial byte enables on writes and on reads show that the byte lanes are independent. A run of mask changes while two flags are pending tells the AND-reduce term apart from a plain flag OR, and shows the one-edge delay of a mask write. Each of the following is tried and must leave every mailbox, flag and mask unchanged:
- a deselected access;
- a memory-mode access;
- an access to a reserved address;
- an access to a read-only address.

A read-clear that coincides with a new write to the same mailbox shows that the set wins.

// File: rtl/xport_mailbox.sv
module xport_mailbox #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_cs_n,
  input  logic          a_mbx_n,
  input  logic          a_we_n,
  input  logic          a_oe_n,
  input  logic [1:0]    a_be_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_cs_n,
  input  logic          b_mbx_n,
  input  logic          b_we_n,
  input  logic          b_oe_n,
  input  logic [1:0]    b_be_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int NB = 4;
  localparam int HB = DW / 2;

  logic [1:0] cs, mb, wen, oen, wr, rd;
  logic [1:0][1:0] ben;
  logic [1:0][AW-1:0] ad;
  logic [1:0][DW-1:0] wd, bm, raw, rdv;
  logic [1:0][NB-1:0][DW-1:0] mbox;
  logic [1:0][NB-1:0] flag, mask, setv, clrv;

  assign cs  = {~b_cs_n, ~a_cs_n};
  assign mb  = {~b_mbx_n, ~a_mbx_n};
  assign wen = {~b_we_n, ~a_we_n};
  assign oen = {~b_oe_n, ~a_oe_n};
  assign ben = {~b_be_n, ~a_be_n};
  assign ad  = {b_addr, a_addr};
  assign wd  = {b_wdata, a_wdata};

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      wr[p] = cs[p] & mb[p] & wen[p];
      rd[p] = cs[p] & mb[p] & oen[p] & ~wen[p];
      bm[p] = {{HB{ben[p][1]}}, {HB{ben[p][0]}}};
    end
    for (int p = 0; p < 2; p++) begin
      setv[p] = '0;
      clrv[p] = '0;
      if (wr[1-p] && ad[1-p][AW-1:2] == '0 && ben[1-p] != 2'b00)
        setv[p][ad[1-p][1:0]] = 1'b1;
      if (rd[p] && ad[p][AW-1:2] == (AW-2)'(1))
        clrv[p][ad[p][1:0]] = 1'b1;
      if (ad[p][AW-1:3] == '0)
        raw[p] = ad[p][2] ? mbox[1-p][ad[p][1:0]] : mbox[p][ad[p][1:0]];
      else if (ad[p] == AW'(8))
        raw[p] = DW'(mask[p]);
      else if (ad[p] == AW'(9))
        raw[p] = DW'(flag[p]);
      else
        raw[p] = '0;
      rdv[p] = rd[p] ? (raw[p] & bm[p]) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbox <= '0;
      flag <= '0;
      mask <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        flag[p] <= (flag[p] & ~clrv[p]) | setv[p];
        if (wr[p] && ad[p][AW-1:2] == '0)
          mbox[p][ad[p][1:0]] <= (mbox[p][ad[p][1:0]] & ~bm[p]) | (wd[p] & bm[p]);
        if (wr[p] && ad[p] == AW'(8) && ben[p][0])
          mask[p] <= wd[p][NB-1:0];
      end
    end
  end

  assign a_rdata = rdv[0];
  assign b_rdata = rdv[1];
  assign a_irq   = |(flag[0] & mask[0]);
  assign b_irq   = |(flag[1] & mask[1]);

  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr[0] && ad[0][AW-1:2] == '0 && ben[0] != 2'b00) |=> flag[1][$past(ad[0][1:0])]);

  a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd[0] && ad[0][AW-1:2] == (AW-2)'(1) && !wr[1]) |=> !flag[0][$past(ad[0][1:0])]);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd[0] && ad[0] == AW'(4) && wr[1] && b_addr == AW'(0) && ben[1] != 2'b00) |=> flag[0][0]);

  a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr[0] && ad[0] == AW'(8) && ben[0][0]) |=> mask[0] == $past(a_wdata[NB-1:0]));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs[0] && !cs[1]) |=> ($stable(flag) && $stable(mask) && $stable(mbox)));

  a_r2_memory_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mbx_n && b_mbx_n) |=> ($stable(flag) && $stable(mask) && $stable(mbox)));
endmodule

// File: tb/xport_mailbox_bench.sv
module xport_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_cs_n = 1'b1, a_mbx_n = 1'b1, a_we_n = 1'b1, a_oe_n = 1'b1;
  logic b_cs_n = 1'b1, b_mbx_n = 1'b1, b_we_n = 1'b1, b_oe_n = 1'b1;
  logic [1:0] a_be_n = 2'b11, b_be_n = 2'b11;
  logic [5:0] a_addr = '0, b_addr = '0;
  logic [15:0] a_wdata = '0, b_wdata = '0;
  logic [15:0] a_rdata, b_rdata;
  logic a_irq, b_irq;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  xport_mailbox u_xport_mailbox (
    .clk(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_mbx_n(a_mbx_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n),
    .a_be_n(a_be_n), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_cs_n(b_cs_n), .b_mbx_n(b_mbx_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n),
    .b_be_n(b_be_n), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input bit p, input logic cs_n, input logic mbx_n, input logic we_n,
                       input logic oe_n, input logic [5:0] ad, input logic [15:0] d,
                       input logic [1:0] be_n);
    if (!p) begin
      a_cs_n = cs_n; a_mbx_n = mbx_n; a_we_n = we_n; a_oe_n = oe_n;
      a_addr = ad; a_wdata = d; a_be_n = be_n;
    end else begin
      b_cs_n = cs_n; b_mbx_n = mbx_n; b_we_n = we_n; b_oe_n = oe_n;
      b_addr = ad; b_wdata = d; b_be_n = be_n;
    end
  endtask

  task automatic idle();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0, 16'h0, 2'b11);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0, 16'h0, 2'b11);
  endtask

  task automatic wr(input bit p, input logic [5:0] ad, input logic [15:0] d, input logic [1:0] be_n);
    drive(p, 1'b0, 1'b0, 1'b0, 1'b1, ad, d, be_n);
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input bit p, input logic [5:0] ad, input logic [1:0] be_n,
                    input logic [15:0] exp, input string tag);
    drive(p, 1'b0, 1'b0, 1'b1, 1'b0, ad, 16'h0, be_n);
    #5;
    chk(tag, p ? b_rdata : a_rdata, exp);
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 a_irq", {15'b0, a_irq}, 16'h0);
    chk("R1 b_irq", {15'b0, b_irq}, 16'h0);
    rd(1'b0, 6'd9, 2'b00, 16'h0, "R1 A flags");
    rd(1'b1, 6'd8, 2'b00, 16'h0, "R1 B mask");
    rd(1'b0, 6'd3, 2'b00, 16'h0, "R1 A mbox3");
  endtask

  task automatic t_message();
    wr(1'b0, 6'd2, 16'h1234, 2'b00);
    rd(1'b1, 6'd9, 2'b00, 16'h0004, "R4 B flag2 set by A");
    rd(1'b0, 6'd9, 2'b00, 16'h0000, "R4 A flags untouched");
    rd(1'b0, 6'd2, 2'b00, 16'h1234, "R3 A readback");
    rd(1'b1, 6'd6, 2'b00, 16'h1234, "R5 B incoming2");
    rd(1'b1, 6'd9, 2'b00, 16'h0000, "R5 B flag2 cleared");
    wr(1'b1, 6'd0, 16'h5A5A, 2'b00);
    rd(1'b0, 6'd9, 2'b00, 16'h0001, "R4 A flag0 set by B");
    rd(1'b0, 6'd4, 2'b00, 16'h5A5A, "R5 A incoming0");
    rd(1'b0, 6'd9, 2'b00, 16'h0000, "R5 A flag0 cleared");
  endtask

  task automatic t_bytes();
    wr(1'b1, 6'd1, 16'hABCD, 2'b10);
    rd(1'b1, 6'd1, 2'b00, 16'h00CD, "R3 low byte only");
    wr(1'b1, 6'd1, 16'hEF99, 2'b01);
    rd(1'b1, 6'd1, 2'b00, 16'hEFCD, "R3 high byte merge");
    rd(1'b1, 6'd1, 2'b01, 16'hEF00, "R9 read high lane");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd1, 16'h0, 2'b00);
    #5;
    chk("R9 oe_n high reads zero", b_rdata, 16'h0);
    @(negedge clk);
    idle();
    rd(1'b0, 6'd5, 2'b00, 16'hEFCD, "R5 A incoming1");
    rd(1'b0, 6'd9, 2'b00, 16'h0000, "R5 A flags clear");
  endtask

  task automatic t_mask();
    wr(1'b0, 6'd8, 16'hFFF1, 2'b00);
    rd(1'b0, 6'd8, 2'b00, 16'h0001, "R7 mask readback");
    chk("R7 irq low no flag", {15'b0, a_irq}, 16'h0);
    wr(1'b1, 6'd0, 16'h0011, 2'b00);
    chk("R7 irq flag0 masked in", {15'b0, a_irq}, 16'h1);
    wr(1'b1, 6'd3, 16'h0033, 2'b00);
    chk("R7 irq still high", {15'b0, a_irq}, 16'h1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd8, 16'h0000, 2'b00);
    #5;
    chk("R7 irq before mask edge", {15'b0, a_irq}, 16'h1);
    @(negedge clk);
    idle();
    chk("R7 irq masked off", {15'b0, a_irq}, 16'h0);
    wr(1'b0, 6'd8, 16'h0008, 2'b10);
    chk("R7 irq flag3 masked in", {15'b0, a_irq}, 16'h1);
    rd(1'b0, 6'd4, 2'b00, 16'h0011, "R5 A incoming0");
    chk("R7 irq held by flag3", {15'b0, a_irq}, 16'h1);
    rd(1'b0, 6'd7, 2'b00, 16'h0033, "R5 A incoming3");
    chk("R7 irq low after clear", {15'b0, a_irq}, 16'h0);
    chk("R7 b_irq unaffected", {15'b0, b_irq}, 16'h0);
  endtask

  task automatic t_collide();
    wr(1'b1, 6'd1, 16'h1111, 2'b00);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd5, 16'h0, 2'b00);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd1, 16'h2222, 2'b00);
    #5;
    chk("R6 read sees old data", a_rdata, 16'h1111);
    @(negedge clk);
    idle();
    rd(1'b0, 6'd9, 2'b00, 16'h0002, "R6 set wins over clear");
    rd(1'b0, 6'd5, 2'b00, 16'h2222, "R6 new message");
    rd(1'b0, 6'd9, 2'b00, 16'h0000, "R6 cleared later");
  endtask

  task automatic t_ignore();
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'd0, 16'hDEAD, 2'b00);
    @(negedge clk);
    idle();
    rd(1'b1, 6'd9, 2'b00, 16'h0000, "R2 memory mode no flag");
    rd(1'b0, 6'd0, 2'b00, 16'h0000, "R2 memory mode no store");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd0, 16'hBEEF, 2'b00);
    @(negedge clk);
    idle();
    rd(1'b0, 6'd0, 2'b00, 16'h0000, "R10 deselected no store");
    rd(1'b1, 6'd9, 2'b00, 16'h0000, "R10 deselected no flag");
    wr(1'b0, 6'd3, 16'h7777, 2'b00);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 6'd7, 16'h0, 2'b00);
    #5;
    chk("R10 deselected read zero", b_rdata, 16'h0);
    @(negedge clk);
    idle();
    rd(1'b1, 6'd9, 2'b00, 16'h0008, "R10 deselected read keeps flag");
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 6'd7, 16'h0, 2'b00);
    #5;
    chk("R2 memory mode read zero", b_rdata, 16'h0);
    @(negedge clk);
    idle();
    rd(1'b1, 6'd9, 2'b00, 16'h0008, "R2 memory read keeps flag");
    rd(1'b1, 6'd7, 2'b00, 16'h7777, "R5 B incoming3");
    wr(1'b0, 6'd9, 16'h000F, 2'b00);
    rd(1'b0, 6'd9, 2'b00, 16'h0000, "R8 flag reg read only");
    wr(1'b1, 6'd5, 16'h4444, 2'b00);
    rd(1'b0, 6'd1, 2'b00, 16'h0000, "R8 incoming write ignored");
    rd(1'b0, 6'd9, 2'b00, 16'h0000, "R8 incoming write no flag");
    wr(1'b0, 6'd10, 16'hFFFF, 2'b00);
    rd(1'b0, 6'd10, 2'b00, 16'h0000, "R8 addr10 zero");
    rd(1'b0, 6'd40, 2'b00, 16'h0000, "R8 addr40 zero");
    rd(1'b0, 6'd8, 2'b00, 16'h0008, "R8 mask unchanged");
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_message();
    t_bytes();
    t_mask();
    t_collide();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule